// File: doc/BRIEF.md
# Trace Buffer Fill Counter

This block stores a stream of 32-bit trace words in a circular buffer of 64 lines, each 64 bits wide. Each line is filled in two halves. A 7-bit fill count advances by one for every stored half. Bits 6:1 of the count give the line being written, and bit 0 picks the half. Software reads the count to learn how much of the buffer is valid. A count of 2k means k complete lines, and an odd count means the newest line holds only its lower half. When the count wraps from 127 to 0, a sticky full flag is set. From then on all 64 lines are valid and the newest data overwrites the oldest.

A capture session starts when the arm input is pulsed. This clears the count and the full flag. The alignment select decides how the session ends:
- End alignment captures from arming onwards, keeps counting through wraps, and stops on the trigger.
- Mid alignment keeps capturing for 64 more halves once the trigger has been seen.
- Begin alignment ignores words until the trigger and stops the moment the buffer becomes full.

The block has two reset inputs. A power-on reset clears the count, the flag and the session. A system reset only ends the session, so after it the count still describes the data captured before it. A separate read port returns any stored line one cycle after its index is presented, and it has no side effects.

Top module: `trace_fill_counter`

## Requirements
- R1: While armed, each cycle with `tw_valid` high that is accepted stores `tw_data` into line `fill_cnt[6:1]`. The data goes to bits 31:0 when `fill_cnt[0]` is 0 and to bits 63:32 when it is 1. `fill_cnt` rises by one on the following edge.
- R2: While not armed, `tw_valid` has no effect: the count, the flag and the stored lines stay unchanged.
- R3: An accepted word at count 127 returns the count to 0 and sets `full`. `full` then stays set until the next arm pulse or power-on reset.
- R4: With `align_sel` = 0 (end alignment, and also code 3), counting continues past a wrap and overwrites the oldest data. A `trig` pulse while armed clears `armed` on the next edge, and a word offered in the trigger cycle is still stored.
- R5: With `align_sel` = 1 (mid alignment), the session ends once 64 words have been accepted counting from the trigger cycle. The word that makes the 64th clears `armed` on the same edge that stores it.
- R6: With `align_sel` = 2 (begin alignment), words before the first trigger are ignored, and a word offered in the trigger cycle is stored. The accepted word that wraps the count clears `armed`.
- R7: An `arm_wr` pulse sets `armed` and clears `fill_cnt` and `full` on the next edge. No word is stored in that cycle.
- R8: With `por_n` low, `fill_cnt`, `full` and `armed` are all 0 after the next edge. `por_n` takes priority over every other input.
- R9: With `sys_rst_n` low, `armed` clears while `fill_cnt`, `full` and the stored lines keep their values.
- R10: `rd_line` shows line `rd_idx`, as it was before that edge's write, one edge after `rd_idx` is sampled. Reads never change the count, the flag or the session.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, synchronous |
| sys_rst_n | input | 1 | System reset, active low, synchronous |
| arm_wr | input | 1 | Arm pulse: start a session |
| align_sel | input | 2 | Trigger alignment: 0 end, 1 mid, 2 begin, 3 as end |
| trig | input | 1 | Trigger event |
| tw_valid | input | 1 | Trace word strobe |
| tw_data | input | 32 | Trace word |
| rd_idx | input | 6 | Line index to read |
| rd_line | output | 64 | Line contents, one cycle after `rd_idx` |
| fill_cnt | output | 7 | Count of valid 32-bit halves, modulo 128 |
| full | output | 1 | Sticky flag: buffer has wrapped |
| armed | output | 1 | Session active |

## Verification
Every result of this block appears one clock edge after the inputs that cause it. This covers the count step, the wrap and its full flag, the arm and disarm decisions for each alignment, both resets, and the read data for an index. The bench drives its inputs on the falling edge. A behavioural model advances on the rising edge in between, and the outputs are compared with that model at the following falling edge. Read data is compared only for lines whose two halves the model has written, and the expected value is taken before that edge's write lands.

// File: rtl/trace_fill_counter.sv
module trace_fill_counter #(
  parameter int LINE_IDX_W = 6,
  parameter int HALF_W     = 32,
  parameter int MID_POST   = 2 ** LINE_IDX_W
) (
  input  logic                    clk,
  input  logic                    por_n,
  input  logic                    sys_rst_n,
  input  logic                    arm_wr,
  input  logic [1:0]              align_sel,
  input  logic                    trig,
  input  logic                    tw_valid,
  input  logic [HALF_W-1:0]       tw_data,
  input  logic [LINE_IDX_W-1:0]   rd_idx,
  output logic [2*HALF_W-1:0]     rd_line,
  output logic [LINE_IDX_W:0]     fill_cnt,
  output logic                    full,
  output logic                    armed
);
  localparam int LINES  = 2 ** LINE_IDX_W;
  localparam int CNT_W  = LINE_IDX_W + 1;
  localparam int LINE_W = 2 * HALF_W;
  localparam int PW     = $clog2(MID_POST + 1);
  localparam logic [1:0] AL_MID = 2'd1, AL_BEGIN = 2'd2;

  logic [CNT_W-1:0]  cnt_q;
  logic              full_q, armed_q, tseen_q;
  logic [PW-1:0]     post_q;
  logic [LINE_W-1:0] buf_q [LINES];

  wire live      = por_n & sys_rst_n & ~arm_wr & armed_q;
  wire trig_now  = tseen_q | trig;
  wire accept    = live & tw_valid & ((align_sel != AL_BEGIN) | trig_now);
  wire wrap      = accept & (&cnt_q);
  wire post_done = accept & trig_now & (post_q == PW'(MID_POST - 1));
  wire stop      = (align_sel == AL_MID)   ? post_done :
                   (align_sel == AL_BEGIN) ? wrap : trig;

  always_ff @(posedge clk) begin
    if (!por_n) begin
      cnt_q <= '0; full_q <= 1'b0; armed_q <= 1'b0; tseen_q <= 1'b0; post_q <= '0;
    end else if (!sys_rst_n) begin
      armed_q <= 1'b0; tseen_q <= 1'b0; post_q <= '0;
    end else if (arm_wr) begin
      cnt_q <= '0; full_q <= 1'b0; armed_q <= 1'b1; tseen_q <= 1'b0; post_q <= '0;
    end else if (armed_q) begin
      if (accept) cnt_q <= cnt_q + 1'b1;
      if (wrap) full_q <= 1'b1;
      if (trig) tseen_q <= 1'b1;
      if (accept && trig_now) post_q <= post_q + 1'b1;
      if (stop) armed_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      if (cnt_q[0]) buf_q[cnt_q[CNT_W-1:1]][LINE_W-1:HALF_W] <= tw_data;
      else          buf_q[cnt_q[CNT_W-1:1]][HALF_W-1:0]      <= tw_data;
    end
    rd_line <= buf_q[rd_idx];
  end

  assign fill_cnt = cnt_q;
  assign full     = full_q;
  assign armed    = armed_q;

  p_step_r1: assert property (@(posedge clk) disable iff (!por_n)
    (sys_rst_n && !arm_wr && armed && tw_valid && align_sel != AL_BEGIN)
      |=> fill_cnt == $past(fill_cnt) + 1'b1);

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!por_n)
    (!armed && !arm_wr) |=> $stable(fill_cnt) && $stable(full) && !armed);

  p_wrap_r3: assert property (@(posedge clk) disable iff (!por_n)
    (accept && fill_cnt == '1) |=> full && fill_cnt == '0);

  p_full_sticky_r3: assert property (@(posedge clk) disable iff (!por_n)
    (full && !arm_wr) |=> full);

  p_end_trig_r4: assert property (@(posedge clk) disable iff (!por_n)
    (armed && sys_rst_n && !arm_wr && trig && (align_sel == 2'd0 || align_sel == 2'd3))
      |=> !armed);

  p_begin_stop_r6: assert property (@(posedge clk) disable iff (!por_n)
    (accept && align_sel == AL_BEGIN && fill_cnt == '1) |=> !armed);

  p_arm_r7: assert property (@(posedge clk) disable iff (!por_n)
    (sys_rst_n && arm_wr) |=> armed && fill_cnt == '0 && !full);

  p_por_r8: assert property (@(posedge clk)
    !por_n |=> fill_cnt == '0 && !full && !armed);

  p_sysrst_r9: assert property (@(posedge clk) disable iff (!por_n)
    !sys_rst_n |=> !armed && $stable(fill_cnt) && $stable(full));
endmodule

// File: tb/test_trace_fill_counter.sv
module test_trace_fill_counter;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        por_n, sys_rst_n, arm_wr, trig, tw_valid;
  logic [1:0]  align_sel;
  logic [31:0] tw_data;
  logic [5:0]  rd_idx;
  logic [63:0] rd_line;
  logic [6:0]  fill_cnt;
  logic        full, armed;

  trace_fill_counter i_trace_fill_counter (
    .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .arm_wr(arm_wr),
    .align_sel(align_sel), .trig(trig), .tw_valid(tw_valid), .tw_data(tw_data),
    .rd_idx(rd_idx), .rd_line(rd_line), .fill_cnt(fill_cnt), .full(full), .armed(armed));

  int checks = 0, failures = 0;
  string cur_req = "R8";

  int m_cnt = 0, m_post = 0;
  bit m_full = 0, m_armed = 0, m_ts = 0;
  logic [31:0] m_lo [64], m_hi [64];
  bit m_wlo [64], m_whi [64];
  logic [63:0] e_rd;
  bit e_rd_ok = 0;

  always @(posedge clk) begin
    bit tn, acc, stp, is_end;
    e_rd_ok = m_wlo[rd_idx] && m_whi[rd_idx];
    e_rd    = {m_hi[rd_idx], m_lo[rd_idx]};
    if (!por_n) begin
      m_cnt = 0; m_full = 0; m_armed = 0; m_ts = 0; m_post = 0;
    end else if (!sys_rst_n) begin
      m_armed = 0; m_ts = 0; m_post = 0;
    end else if (arm_wr) begin
      m_cnt = 0; m_full = 0; m_armed = 1; m_ts = 0; m_post = 0;
    end else if (m_armed) begin
      tn = m_ts || trig;
      is_end = (align_sel == 2'd0 || align_sel == 2'd3);
      acc = tw_valid && (align_sel != 2'd2 || tn);
      stp = is_end && trig;
      if (acc) begin
        if (m_cnt % 2 == 0) begin m_lo[m_cnt/2] = tw_data; m_wlo[m_cnt/2] = 1; end
        else begin m_hi[m_cnt/2] = tw_data; m_whi[m_cnt/2] = 1; end
        m_cnt = m_cnt + 1;
        if (m_cnt == 128) begin
          m_cnt = 0; m_full = 1;
          if (align_sel == 2'd2) stp = 1;
        end
        if (tn) begin
          m_post = m_post + 1;
          if (align_sel == 2'd1 && m_post == 64) stp = 1;
        end
      end
      if (trig) m_ts = 1;
      if (stp) m_armed = 0;
    end
  end

  task automatic compare();
    checks++;
    if (fill_cnt !== 7'(m_cnt) || full !== m_full || armed !== m_armed) begin
      failures++;
      $display("FAIL %s cnt/full/armed actual=%0d/%0b/%0b expected=%0d/%0b/%0b",
               cur_req, fill_cnt, full, armed, m_cnt, m_full, m_armed);
    end
    if (e_rd_ok) begin
      checks++;
      if (rd_line !== e_rd) begin
        failures++;
        $display("FAIL %s rd_line actual=%h expected=%h", cur_req, rd_line, e_rd);
      end
    end
  endtask

  task automatic step();
    @(negedge clk);
    compare();
  endtask

  int word_n = 0;
  task automatic push(int n);
    for (int k = 0; k < n; k++) begin
      tw_valid = 1'b1;
      tw_data  = 32'hC3A5_0000 ^ (word_n * 32'h0001_0F1B);
      rd_idx   = 6'(word_n);
      word_n++;
      step();
    end
    tw_valid = 1'b0;
  endtask

  task automatic arm(logic [1:0] mode);
    align_sel = mode; arm_wr = 1'b1; step(); arm_wr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired in %s", cur_req);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) begin m_wlo[i] = 0; m_whi[i] = 0; end
    por_n = 0; sys_rst_n = 1; arm_wr = 0; trig = 0; tw_valid = 0;
    align_sel = 0; tw_data = 0; rd_idx = 0;
    cur_req = "R8"; repeat (3) step(); por_n = 1;
    cur_req = "R2"; push(5);
    cur_req = "R7"; arm(2'd0);
    cur_req = "R1"; push(5);
    cur_req = "R10";
    for (int i = 0; i < 3; i++) begin rd_idx = 6'(i); step(); end
    cur_req = "R9"; sys_rst_n = 0; repeat (2) step(); sys_rst_n = 1; push(3);
    cur_req = "R7"; arm(2'd0);
    cur_req = "R3"; push(130);
    cur_req = "R4"; trig = 1; push(1); trig = 0; push(4);
    cur_req = "R5"; arm(2'd1); push(10); trig = 1; push(1); trig = 0; push(80);
    cur_req = "R6"; arm(2'd2); push(5); trig = 1; push(1); trig = 0; push(140);
    cur_req = "R10";
    for (int i = 0; i < 64; i++) begin rd_idx = 6'(i); step(); end
    cur_req = "R4"; arm(2'd3); push(4); trig = 1; step(); trig = 0; push(2);
    cur_req = "R8"; arm(2'd0); push(7); por_n = 0; step(); por_n = 1; step();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule